// File: doc/BRIEF.md
# Packet Buffer Allocator with Command Queue

This block is the buffer manager of a small Ethernet controller. It owns a pool of packet buffers (four by default) and tracks which are in use with an allocation bitmap. Three shift-on-pop queues of the same depth sit beside it. The transmit queue holds buffers waiting to be sent. The transmit-done queue holds sent buffers that software has not yet taken back. The receive queue holds buffers that hold received frames. Packet data storage, the serialiser and the host bus decoder are outside this block.

The host drives a 3-bit command with a packet number. The receive path asks for buffers over a valid/ready request, and each accepted request gets a response one cycle later. The transmitter takes buffers from the head of the transmit queue over a valid/ready stream. Back-pressure works like this: `rx_req_valid` is held until `rx_req_ready` is seen high. The transmit head stays on `txq_num` until the cycle in which `txq_valid` and `txq_ready` are both high. The response `rx_resp_*` and all status pins are plain and cannot be stalled. A host command and a receive request in the same cycle are serialised, and the host command always goes first.

Allocation always returns the lowest-numbered free buffer. When no buffer is free it returns the code 0x80. If a transmit allocation fails, it stays pending and is retried automatically as soon as any buffer is freed.

Top module: `pba_alloc_unit`

## Requirements
- R1: An accepted receive request (`rx_req_valid` and `rx_req_ready` high at a clock edge) produces `rx_resp_valid` high for exactly the next cycle. `rx_resp_num` then holds the lowest free buffer number, or 0x80 if every buffer is taken. A granted buffer is marked in use and appended to the receive queue.
- R2: When `cmd_valid` is high, `cmd_code` selects the action: 0 none, 1 transmit allocate, 2 unit reset, 3 drop receive head, 4 drop receive head and free its buffer, 5 free `pkt_num`, 6 queue `pkt_num` for transmit, 7 clear both transmit queues. Code 0 changes no output.
- R3: Code 1 first sets `alloc_result` to 0x80 and clears `ev_alloc_done`. If a buffer is free, `alloc_result` takes the lowest free number and `ev_alloc_done` is set. Both are visible the cycle after the command.
- R4: While `alloc_result` is 0x80, any cycle that frees a buffer also allocates the lowest free buffer into `alloc_result` and sets `ev_alloc_done`.
- R5: Code 2 empties the bitmap and all three queues and sets `alloc_result` to 0. `ev_alloc_done` keeps its value.
- R6: `rx_head` and `txdone_head` read 0x80 when their queue is empty. Otherwise they give the head entry, zero-extended to 8 bits.
- R7: When a buffer leaves the transmit queue, it is freed if `auto_release` is high. Otherwise it is appended to the transmit-done queue if that queue was not full; if it was full, the buffer is dropped. `txdone_pop` removes the done-queue head if one exists.
- R8: Code 6 while the transmit queue holds four entries is ignored.
- R9: Codes 3 and 4 do nothing on an empty receive queue. Code 3 leaves the dropped buffer allocated. Code 4 frees it.
- R10: Code 5 clears the bitmap bit of `pkt_num`.
- R11: `rx_req_ready` is low whenever `cmd_valid` is high, and also whenever an automatic retry (R4) takes place in that cycle.
- R12: `in_use` equals the number of buffers marked in use. `total_bufs` is the constant pool size, 4.
- R13: `txq_valid` is high when the transmit queue is non-empty, and `txq_num` is then its head. A handshake removes the head. Code 7 empties the transmit and transmit-done queues.
- R14: `ev_rx_pending` is high when the receive queue is non-empty. `ev_tx_done` is high when the done queue is non-empty. `ev_tx_empty` is high when the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host command strobe, one cycle per command |
| cmd_code | input | 3 | Host command code |
| pkt_num | input | 2 | Packet-number register value used by codes 5 and 6 |
| auto_release | input | 1 | Free transmitted buffers instead of reporting them |
| rx_req_valid | input | 1 | Receive path requests a buffer |
| rx_req_ready | output | 1 | Receive request accepted this cycle |
| rx_resp_valid | output | 1 | Receive allocation response strobe |
| rx_resp_num | output | 8 | Granted buffer or 0x80 |
| txq_valid | output | 1 | Transmit queue head is present |
| txq_num | output | 2 | Transmit queue head buffer |
| txq_ready | input | 1 | Transmitter takes the head |
| txdone_pop | input | 1 | Host acknowledges the done-queue head |
| alloc_result | output | 8 | Transmit allocation result |
| rx_head | output | 8 | Receive queue head or 0x80 |
| txdone_head | output | 8 | Transmit-done queue head or 0x80 |
| in_use | output | 3 | Number of allocated buffers |
| total_bufs | output | 3 | Pool size constant |
| ev_alloc_done | output | 1 | Transmit allocation succeeded |
| ev_rx_pending | output | 1 | Receive queue non-empty |
| ev_tx_done | output | 1 | Done queue non-empty |
| ev_tx_empty | output | 1 | Transmit queue empty |

## Verification
The hardest state to reach is a pending transmit allocation that is then resolved by a free. This needs a full pool first, a failed code 1 next, and finally a free that arrives through code 4, code 5 or an auto-released transmit handshake. The retry must also be seen to close `rx_req_ready` in that same cycle. Directed sequences fill the pool through receive requests before each kind of free. Seeded random traffic then mixes all commands, transmit handshakes and done acknowledgements, and a bench model predicts every output in every cycle, so the three free sources also collide with one another and with receive requests.

// File: rtl/pba_pkg.sv
package pba_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_TX_ALLOC = 3'd1,
    CMD_RESET    = 3'd2,
    CMD_RX_DROP  = 3'd3,
    CMD_RX_FREE  = 3'd4,
    CMD_FREE_NUM = 3'd5,
    CMD_TX_QUEUE = 3'd6,
    CMD_TX_FLUSH = 3'd7
  } pba_cmd_e;

  // returned in place of a buffer number when nothing is available
  localparam logic [7:0] PBA_NONE = 8'h80;
endpackage

// File: rtl/pba_pick_free.sv
module pba_pick_free #(
  parameter int unsigned NBUF = 4,
  localparam int unsigned IDW = $clog2(NBUF)
) (
  input  logic [NBUF-1:0] busy,
  output logic            found,
  output logic [IDW-1:0]  idx
);
  // priority chain: position i wins if it is free and no lower one is
  logic [NBUF-1:0] lower_free;
  logic [NBUF-1:0] win;

  genvar i;
  generate
    for (i = 0; i < NBUF; i++) begin : g_chain
      if (i == 0) begin : g_first
        assign lower_free[i] = 1'b0;
      end else begin : g_rest
        assign lower_free[i] = lower_free[i-1] | ~busy[i-1];
      end
      assign win[i] = ~busy[i] & ~lower_free[i];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int k = 0; k < NBUF; k++) begin
      if (win[k]) idx = IDW'(k);
    end
  end

  assign found = |win;
endmodule

// File: rtl/pba_popcount.sv
module pba_popcount #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 3
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] total
);
  always_comb begin
    total = '0;
    for (int k = 0; k < N; k++) begin
      total = total + CW'(bits[k]);
    end
  end
endmodule

// File: rtl/pba_shift_queue.sv
module pba_shift_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 2,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [W-1:0]  slot_d [DEPTH];
  logic [W-1:0]  moved  [DEPTH];
  logic [CW-1:0] cnt_q, cnt_mid, cnt_d;
  logic          pop_ok, push_ok;

  assign pop_ok  = pop && (cnt_q != '0);
  // fullness is judged before any pop of the same cycle
  assign push_ok = push && (cnt_q != CW'(DEPTH));
  assign cnt_mid = cnt_q - CW'(pop_ok);
  assign cnt_d   = cnt_mid + CW'(push_ok);

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_slot
      if (i == DEPTH - 1) begin : g_tail
        assign moved[i] = pop_ok ? '0 : slot_q[i];
      end else begin : g_body
        assign moved[i] = pop_ok ? slot_q[i+1] : slot_q[i];
      end
      assign slot_d[i] = (push_ok && (cnt_mid == CW'(i))) ? push_data : moved[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
    end else if (clear) begin
      cnt_q <= '0;
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int k = 0; k < DEPTH; k++) slot_q[k] <= slot_d[k];
    end
  end

  assign head  = slot_q[0];
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/pba_alloc_unit.sv
module pba_alloc_unit
  import pba_pkg::*;
#(
  parameter int unsigned NBUF = 4,
  localparam int unsigned IDW  = $clog2(NBUF),
  localparam int unsigned CNTW = $clog2(NBUF + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_code,
  input  logic [IDW-1:0]  pkt_num,
  input  logic            auto_release,
  input  logic            rx_req_valid,
  output logic            rx_req_ready,
  output logic            rx_resp_valid,
  output logic [7:0]      rx_resp_num,
  output logic            txq_valid,
  output logic [IDW-1:0]  txq_num,
  input  logic            txq_ready,
  input  logic            txdone_pop,
  output logic [7:0]      alloc_result,
  output logic [7:0]      rx_head,
  output logic [7:0]      txdone_head,
  output logic [CNTW-1:0] in_use,
  output logic [CNTW-1:0] total_bufs,
  output logic            ev_alloc_done,
  output logic            ev_rx_pending,
  output logic            ev_tx_done,
  output logic            ev_tx_empty
);
  localparam int unsigned PADW = 8 - IDW;

  pba_cmd_e cmd;
  assign cmd = pba_cmd_e'(cmd_code);

  logic do_reset, do_flush, do_alloc, do_drop, do_drop_free, do_free_num, do_queue;
  assign do_reset     = cmd_valid && (cmd == CMD_RESET);
  assign do_flush     = cmd_valid && (cmd == CMD_TX_FLUSH);
  assign do_alloc     = cmd_valid && (cmd == CMD_TX_ALLOC);
  assign do_drop      = cmd_valid && (cmd == CMD_RX_DROP);
  assign do_drop_free = cmd_valid && (cmd == CMD_RX_FREE);
  assign do_free_num  = cmd_valid && (cmd == CMD_FREE_NUM);
  assign do_queue     = cmd_valid && (cmd == CMD_TX_QUEUE);

  logic [NBUF-1:0] bitmap_q, bitmap_d, free_mask, avail;
  logic [7:0]      alloc_q, alloc_d;
  logic            done_q, done_d;
  logic            resp_v_q;
  logic [7:0]      resp_n_q;

  logic            found;
  logic [IDW-1:0]  pick;
  logic [7:0]      pick_code;

  logic [IDW-1:0]  tx_head, dn_head, rx_head_id;
  logic            tx_empty, dn_empty, rx_empty;
  logic            tx_pop, retry, rx_take, grant;

  assign tx_pop = !tx_empty && txq_ready;

  // buffers released this cycle, from any of the three sources
  always_comb begin
    free_mask = '0;
    if (!do_reset) begin
      if (tx_pop && auto_release)      free_mask[tx_head]    = 1'b1;
      if (do_drop_free && !rx_empty)   free_mask[rx_head_id] = 1'b1;
      if (do_free_num)                 free_mask[pkt_num]    = 1'b1;
    end
  end

  assign avail = bitmap_q & ~free_mask;

  pba_pick_free #(.NBUF(NBUF)) u_pick (
    .busy  (avail),
    .found (found),
    .idx   (pick)
  );

  assign pick_code = found ? {{PADW{1'b0}}, pick} : PBA_NONE;

  // a single allocator: host command, then pending retry, then receive
  assign retry        = (alloc_q == PBA_NONE) && (|free_mask) && !do_alloc;
  assign rx_req_ready = !cmd_valid && !retry;
  assign rx_take      = rx_req_valid && rx_req_ready;
  assign grant        = found && (do_alloc || retry || rx_take);

  always_comb begin
    bitmap_d = avail;
    if (grant) bitmap_d[pick] = 1'b1;
    if (do_reset) bitmap_d = '0;
  end

  always_comb begin
    alloc_d = alloc_q;
    done_d  = done_q;
    if (do_reset) begin
      alloc_d = '0;
    end else if (do_alloc) begin
      alloc_d = pick_code;
      done_d  = found;
    end else if (retry) begin
      alloc_d = pick_code;
      done_d  = done_q | found;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitmap_q <= '0;
      alloc_q  <= '0;
      done_q   <= 1'b0;
      resp_v_q <= 1'b0;
      resp_n_q <= '0;
    end else begin
      bitmap_q <= bitmap_d;
      alloc_q  <= alloc_d;
      done_q   <= done_d;
      resp_v_q <= rx_take;
      resp_n_q <= rx_take ? pick_code : resp_n_q;
    end
  end

  pba_shift_queue #(.DEPTH(NBUF), .W(IDW)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (do_reset || do_flush),
    .push      (do_queue),
    .push_data (pkt_num),
    .pop       (tx_pop),
    .head      (tx_head),
    .empty     (tx_empty)
  );

  pba_shift_queue #(.DEPTH(NBUF), .W(IDW)) u_doneq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (do_reset || do_flush),
    .push      (tx_pop && !auto_release),
    .push_data (tx_head),
    .pop       (txdone_pop),
    .head      (dn_head),
    .empty     (dn_empty)
  );

  pba_shift_queue #(.DEPTH(NBUF), .W(IDW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (do_reset),
    .push      (rx_take && found),
    .push_data (pick),
    .pop       (do_drop || do_drop_free),
    .head      (rx_head_id),
    .empty     (rx_empty)
  );

  pba_popcount #(.N(NBUF), .CW(CNTW)) u_count (
    .bits  (bitmap_q),
    .total (in_use)
  );

  assign total_bufs    = CNTW'(NBUF);
  assign alloc_result  = alloc_q;
  assign ev_alloc_done = done_q;
  assign rx_resp_valid = resp_v_q;
  assign rx_resp_num   = resp_n_q;
  assign txq_valid     = !tx_empty;
  assign txq_num       = tx_head;
  assign rx_head       = rx_empty ? PBA_NONE : {{PADW{1'b0}}, rx_head_id};
  assign txdone_head   = dn_empty ? PBA_NONE : {{PADW{1'b0}}, dn_head};
  assign ev_rx_pending = !rx_empty;
  assign ev_tx_done    = !dn_empty;
  assign ev_tx_empty   = tx_empty;
endmodule

// File: rtl/pba_alloc_checks.sv
module pba_alloc_checks
  import pba_pkg::*;
#(
  parameter int unsigned NBUF = 4,
  localparam int unsigned CNTW = $clog2(NBUF + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [2:0]      cmd_code,
  input logic            rx_req_ready,
  input logic            rx_resp_valid,
  input logic [7:0]      rx_resp_num,
  input logic            txq_valid,
  input logic [7:0]      alloc_result,
  input logic [7:0]      rx_head,
  input logic [7:0]      txdone_head,
  input logic [CNTW-1:0] in_use,
  input logic            ev_alloc_done
);
  p_fail_when_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_resp_valid && (rx_resp_num == PBA_NONE) |-> $past(in_use) == CNTW'(NBUF));

  p_grant_queued_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_resp_valid && (rx_resp_num != PBA_NONE) |-> rx_head != PBA_NONE);

  p_done_matches_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_code == 3'd1) |=> ev_alloc_done == (alloc_result != PBA_NONE));

  p_retry_on_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_code == 3'd5) && (alloc_result == PBA_NONE)
      |=> (alloc_result != PBA_NONE) && ev_alloc_done);

  p_unit_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_code == 3'd2) |=> (in_use == '0) && (alloc_result == 8'h00)
      && (rx_head == PBA_NONE) && (txdone_head == PBA_NONE) && !txq_valid);

  p_host_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rx_req_ready);
endmodule

bind pba_alloc_unit pba_alloc_checks #(.NBUF(NBUF)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_code      (cmd_code),
  .rx_req_ready  (rx_req_ready),
  .rx_resp_valid (rx_resp_valid),
  .rx_resp_num   (rx_resp_num),
  .txq_valid     (txq_valid),
  .alloc_result  (alloc_result),
  .rx_head       (rx_head),
  .txdone_head   (txdone_head),
  .in_use        (in_use),
  .ev_alloc_done (ev_alloc_done)
);

// File: tb/sim_pba_alloc_unit.sv
`timescale 1ns/1ps
module sim_pba_alloc_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = '0;
  logic [1:0] pkt_num = '0;
  logic       auto_release = 1'b0;
  logic       rx_req_valid = 1'b0;
  logic       rx_req_ready;
  logic       rx_resp_valid;
  logic [7:0] rx_resp_num;
  logic       txq_valid;
  logic [1:0] txq_num;
  logic       txq_ready = 1'b0;
  logic       txdone_pop = 1'b0;
  logic [7:0] alloc_result, rx_head, txdone_head;
  logic [2:0] in_use, total_bufs;
  logic       ev_alloc_done, ev_rx_pending, ev_tx_done, ev_tx_empty;

  always #2.5 clk = ~clk;

  pba_alloc_unit u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  string phase = "reset";

  // bench model of the requirements
  int m_bmap = 0, m_res = 0, m_done = 0, m_resp_v = 0, m_resp_n = 0;
  int txq[4], dq[4], rq[4];
  int txc = 0, dc = 0, rc = 0;

  function automatic int lowest(int avail_busy);
    for (int k = 0; k < 4; k++) if (((avail_busy >> k) & 1) == 0) return k;
    return 128;
  endfunction

  function automatic int popc(int v);
    int s = 0;
    for (int k = 0; k < 4; k++) s += (v >> k) & 1;
    return s;
  endfunction

  task automatic chk(string req, string name, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s (%s) %s: got %0h expected %0h", req, phase, name, got, exp);
    end
  endtask

  task automatic model_step(int cv, int cc, int pn, int ar, int rv, int tr, int dp, output int rdy);
    int fm = 0;
    int txpop = (txc > 0) && tr;
    int popped = txq[0];
    int rst = cv && cc == 2;
    int retry, avail, lo, take, tfull, dfull;
    if (!rst) begin
      if (txpop && ar) fm |= 1 << popped;
      if (cv && cc == 4 && rc > 0) fm |= 1 << rq[0];
      if (cv && cc == 5) fm |= 1 << pn;
    end
    retry = (m_res == 128) && (fm != 0) && !(cv && cc == 1);
    rdy = !cv && !retry;
    avail = m_bmap & ~fm;
    lo = lowest(avail);
    take = rv && rdy;
    m_resp_v = take;
    if (take) m_resp_n = lo;
    if (rst) begin
      m_bmap = 0; txc = 0; dc = 0; rc = 0; m_res = 0;
      return;
    end
    tfull = (txc == 4);
    dfull = (dc == 4);
    if (txpop) begin
      for (int k = 0; k < 3; k++) txq[k] = txq[k+1];
      txc--;
    end
    if (cv && cc == 6 && !tfull) begin txq[txc] = pn; txc++; end
    if (dp && dc > 0) begin
      for (int k = 0; k < 3; k++) dq[k] = dq[k+1];
      dc--;
    end
    if (txpop && !ar && !dfull) begin dq[dc] = popped; dc++; end
    if (cv && cc == 7) begin txc = 0; dc = 0; end
    if (cv && (cc == 3 || cc == 4) && rc > 0) begin
      for (int k = 0; k < 3; k++) rq[k] = rq[k+1];
      rc--;
    end
    if (take && lo != 128 && rc < 4) begin rq[rc] = lo; rc++; end
    if (cv && cc == 1) begin
      m_res = lo; m_done = (lo != 128);
      if (lo != 128) avail |= 1 << lo;
    end else if (retry) begin
      m_res = lo; m_done = 1;
      avail |= 1 << lo;
    end else if (take && lo != 128) begin
      avail |= 1 << lo;
    end
    m_bmap = avail;
  endtask

  task automatic check_outputs();
    chk("R3", "alloc_result", alloc_result, m_res);
    chk("R3", "ev_alloc_done", ev_alloc_done, m_done);
    chk("R9", "rx_head", rx_head, rc > 0 ? rq[0] : 128);
    chk("R7", "txdone_head", txdone_head, dc > 0 ? dq[0] : 128);
    chk("R13", "txq_valid", txq_valid, txc > 0);
    if (txc > 0) chk("R13", "txq_num", txq_num, txq[0]);
    chk("R12", "in_use", in_use, popc(m_bmap));
    chk("R12", "total_bufs", total_bufs, 4);
    chk("R1", "rx_resp_valid", rx_resp_valid, m_resp_v);
    if (m_resp_v) chk("R1", "rx_resp_num", rx_resp_num, m_resp_n);
    chk("R14", "ev_rx_pending", ev_rx_pending, rc > 0);
    chk("R14", "ev_tx_done", ev_tx_done, dc > 0);
    chk("R14", "ev_tx_empty", ev_tx_empty, txc == 0);
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic cyc(int cv, int cc, int pn, int ar, int rv, int tr, int dp);
    int rdy;
    cmd_valid = cv[0]; cmd_code = cc[2:0]; pkt_num = pn[1:0];
    auto_release = ar[0]; rx_req_valid = rv[0]; txq_ready = tr[0]; txdone_pop = dp[0];
    #1;
    model_step(cv, cc, pn, ar, rv, tr, dp, rdy);
    chk("R11", "rx_req_ready", rx_req_ready, rdy);
    @(posedge clk);
    #1;
    check_outputs();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs();                          // reset state

    phase = "R2 nop";                         // code 0 changes nothing, blocks rx
    cyc(1, 0, 2, 0, 1, 0, 0);

    phase = "R1 lowest free";
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, 0, 0);   // 0,1,2,3 then 0x80

    phase = "R10 free by number";
    cyc(1, 5, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0);                 // regains buffer 1

    phase = "R9 drop heads";
    cyc(1, 3, 0, 0, 0, 0, 0);                 // drops 0, stays allocated
    cyc(1, 4, 0, 0, 0, 0, 0);                 // drops 1 and frees it
    cyc(0, 0, 0, 0, 1, 0, 0);                 // pool full again

    phase = "R4 pending retry";
    cyc(1, 1, 0, 0, 0, 0, 0);                 // fails: 0x80
    chk("R4", "alloc pending", alloc_result, 128);
    cyc(1, 5, 2, 0, 0, 0, 0);                 // free 2 -> retry grabs 2
    chk("R4", "alloc after free", alloc_result, 2);

    phase = "R5 reset";
    cyc(1, 2, 0, 0, 0, 0, 0);
    phase = "R6 empty heads";
    chk("R6", "rx_head empty", rx_head, 128);
    chk("R6", "txdone_head empty", txdone_head, 128);

    phase = "R8 full txq";
    for (int i = 0; i < 4; i++) cyc(1, 6, i, 0, 0, 0, 0);
    cyc(1, 6, 3, 0, 0, 0, 0);                 // fifth push ignored
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R8", "only four drained", txdone_head, 0);

    phase = "R7 done queue";
    cyc(0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(1, 6, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 1, 0);                 // auto release frees buffer 0

    phase = "R13 flush";
    cyc(1, 6, 1, 0, 0, 0, 0);
    cyc(1, 6, 2, 0, 0, 0, 0);
    cyc(1, 7, 0, 0, 0, 0, 0);

    phase = "random";
    for (int i = 0; i < 3000; i++) begin
      int cv = ($urandom % 10) < 4;
      int cc = $urandom % 8;
      if (cc == 2 && ($urandom % 8) != 0) cc = 1;
      cyc(cv, cc, $urandom % 4, $urandom % 2, $urandom % 2,
          $urandom % 2, ($urandom % 4) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule